// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is the station-management master of an Ethernet MAC. A host writes a single command word to start a transaction. The word selects a read or a write and names a PHY and one of its registers. The engine then generates the management clock and runs one complete frame on the MDIO line. While the frame is in flight it reports busy, and the host polls that flag.

For a write, the host first loads the 16-bit value into the data register and then issues the command. For a read, the engine samples the PHY's answer and places it in the same data register. The new value is visible in the cycle where busy reads low.

A control register holds two settings:
- the clock divisor, stored as the divisor minus one, with a default of 40;
- an option that omits the 32-bit preamble, for PHYs that accept short frames.

A self-clear bit in the control register abandons any frame in flight and returns the engine to its reset state.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no handshake: every write is taken in the cycle it is presented. The MDIO pad is split into an output, an output enable and an input.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the engine is idle. MDC is low and MDIO is not driven. The data register reads 0. The control register reads the divisor field as 39 in bits 15:9, with preamble suppression (bit 8) and self-clear (bit 0) both 0.
- R2: A write to the command register (index 0) starts a frame.
  - Bit 15 selects a read and bit 14 selects a write. When both are set, the read wins.
  - Bits 9:5 carry the PHY address and bits 4:0 carry the register number.
  - A word with neither bit 15 nor bit 14 set starts nothing.
- R3: A frame is sent most significant bit first, in this order: 32 ones of preamble (unless suppressed), start 01, opcode 10 for a read or 01 for a write, PHY address, register number, turnaround, 16 data bits.
- R4: In a write frame the turnaround is driven as 10, followed by the 16-bit value of the data register (index 1). MDIO is driven for the whole frame.
- R5: In a read frame MDIO is released from the first turnaround bit to the end of the frame. The 16 data bits are sampled on rising MDC edges and appear in the data register in the cycle where busy first reads 0.
- R6: Status bit 0 (index 2) reads 1 from the cycle after an accepted command for exactly N×D clock cycles. N is the number of frame bits and D is the MDC divisor.
- R7: While busy, MDC has period D = control bits 15:9 plus one. A field value of 0 is treated as D = 2. Each MDC period is low for floor(D/2) cycles and then high for the rest. MDC stays low while idle.
- R8: With control bit 8 set, the preamble is omitted and a frame is 32 bits long.
- R9: While busy, writes to the command register, the data register and the divisor and suppression fields of the control register are ignored.
- R10: Writing 1 to control bit 0 makes the bit read 1 for one cycle. The engine then abandons any frame, clears the data register, restores the control defaults, stops MDC and releases MDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write register index: 0 command, 1 data, 2 status, 3 control |
| reg_wdata | input | 16 | Write data |
| reg_rd_addr | input | 2 | Read register index |
| reg_rdata | output | 16 | Read data for reg_rd_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The following internal faults show up at the ports within one MDC period:
- A wrong bit counter or shift register shows at the first rising MDC edge after the fault, as a frame bit out of sequence or an early or late release of MDIO.
- A faulty clock divider shows in the MDC low and high widths.
- A faulty divider also changes the exact count of busy cycles, which the host sees as soon as the frame ends.

A wrong opcode or release decode makes a read return data other than the PHY's reply, visible in the data register in the cycle busy falls. A busy flag that fails to guard the registers shows as a changed frame or a changed data or control read-back after the blocked writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_PHY_LSB = 5;
  localparam int CMD_REG_LSB = 0;
  localparam int CTL_DIV_LSB = 9;
  localparam int CTL_SUP_BIT = 8;
  localparam int CTL_CLR_BIT = 0;
  localparam int PRE_BITS    = 32;
  localparam int BODY_BITS   = 32;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] period;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt;

  // A divisor of 1 is clamped to 2 so MDC always has a high and a low phase
  assign period = (div_m1 == '0) ? CW'(2) : ({1'b0, div_m1} + CW'(1));
  assign half    = period >> 1;
  assign rise_ev = run && (cnt == half - CW'(1));
  assign fall_ev = run && (cnt == period - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_ev) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
      if (rise_ev) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        start,
  input  logic        is_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        sup,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_word
);
  localparam int TOT  = PRE_BITS + BODY_BITS;
  localparam int IW   = $clog2(TOT + 1);
  localparam int TA_Q = 14;
  localparam int DQ_Q = 16;

  logic [TOT-1:0]       shreg;
  logic [IW-1:0]        bit_idx;
  logic [IW-1:0]        last_idx;
  logic                 rd_l;
  logic                 sup_l;
  logic [BODY_BITS-1:0] body;
  logic [IW-1:0]        q;
  logic                 in_body;
  logic                 released;

  assign body = {2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad,
                 (is_rd ? 2'b11 : 2'b10), (is_rd ? 16'hFFFF : wdata)};

  // Position inside the 32-bit body, valid when in_body is set
  assign q        = sup_l ? bit_idx : (bit_idx - IW'(PRE_BITS));
  assign in_body  = sup_l || (bit_idx >= IW'(PRE_BITS));
  assign released = rd_l && in_body && (q >= IW'(TA_Q));
  assign mdio_oe  = busy && !released;
  assign mdio_o   = mdio_oe && shreg[TOT-1];
  assign done     = busy && fall_ev && (bit_idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy     <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      rd_l     <= 1'b0;
      sup_l    <= 1'b0;
      rd_word  <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      shreg    <= sup ? {body, {PRE_BITS{1'b0}}} : {{PRE_BITS{1'b1}}, body};
      bit_idx  <= '0;
      last_idx <= sup ? IW'(BODY_BITS - 1) : IW'(TOT - 1);
      rd_l     <= is_rd;
      sup_l    <= sup;
      rd_word  <= '0;
    end else if (busy) begin
      if (rise_ev && rd_l && in_body && (q >= IW'(DQ_Q)))
        rd_word <= {rd_word[14:0], mdio_i};
      if (fall_ev) begin
        if (bit_idx == last_idx) begin
          busy <= 1'b0;
        end else begin
          bit_idx <= bit_idx + IW'(1);
          shreg   <= {shreg[TOT-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int DEF_DIV = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [1:0]       reg_rd_addr,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam logic [DIV_W-1:0] DEF_M1 = DIV_W'(DEF_DIV - 1);

  logic [DIV_W-1:0] div_m1;
  logic             pre_sup;
  logic             srst_pend;
  logic [15:0]      data_q;
  logic [15:0]      cmd_q;
  logic             busy;
  logic             done;
  logic [15:0]      rd_word;
  logic             rise_ev;
  logic             fall_ev;
  logic             start;
  logic             wr_open;
  logic [REG_W-1:0] ctrl_rd;
  logic             unused_ctl;

  assign unused_ctl = ^reg_wdata[CTL_SUP_BIT-1:CTL_CLR_BIT+1];
  assign wr_open    = reg_wr && !busy && !srst_pend;
  assign start      = wr_open && (reg_addr == SEL_CMD) &&
                      (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n || srst_pend) begin
      div_m1    <= DEF_M1;
      pre_sup   <= 1'b0;
      srst_pend <= 1'b0;
      data_q    <= '0;
      cmd_q     <= '0;
    end else begin
      // Self-clear request is honoured even mid-frame
      if (reg_wr && reg_addr == SEL_CTRL && reg_wdata[CTL_CLR_BIT])
        srst_pend <= 1'b1;
      else if (wr_open && reg_addr == SEL_CTRL) begin
        div_m1  <= reg_wdata[CTL_DIV_LSB +: DIV_W];
        pre_sup <= reg_wdata[CTL_SUP_BIT];
      end
      if (start) begin
        // Read wins when both opcode bits are set
        cmd_q <= reg_wdata[CMD_RD_BIT] ? {1'b1, 1'b0, reg_wdata[13:0]} : reg_wdata;
      end
      if (done && cmd_q[CMD_RD_BIT])
        data_q <= rd_word;
      else if (wr_open && reg_addr == SEL_DATA)
        data_q <= reg_wdata;
    end
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst_pend),
    .run     (busy),
    .div_m1  (div_m1),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst_pend),
    .start   (start),
    .is_rd   (reg_wdata[CMD_RD_BIT]),
    .phy     (reg_wdata[CMD_PHY_LSB +: 5]),
    .regad   (reg_wdata[CMD_REG_LSB +: 5]),
    .wdata   (data_q),
    .sup     (pre_sup),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_word (rd_word)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_DIV_LSB +: DIV_W] = div_m1;
    ctrl_rd[CTL_SUP_BIT]          = pre_sup;
    ctrl_rd[CTL_CLR_BIT]          = srst_pend;
  end

  always_comb begin
    case (reg_rd_addr)
      SEL_CMD:  reg_rdata = cmd_q;
      SEL_DATA: reg_rdata = data_q;
      SEL_STAT: reg_rdata = {{(REG_W-1){1'b0}}, busy};
      default:  reg_rdata = ctrl_rd;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] cmd_q,
  input logic        srst_pend
);
  // R7
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R7
  mdc_rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  // R6
  cmd_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && (reg_wdata[15] || reg_wdata[14]) && !busy && !srst_pend)
      |=> busy);

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst_pend && reg_wr && reg_addr == 2'd0) |=> $stable(cmd_q));

  // R10
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> (!busy && !srst_pend && !mdc));
endmodule

bind mdio_mgmt_engine mdio_mgmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mdc       (mdc),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cmd_q     (cmd_q),
  .srst_pend (srst_pend)
);

// File: tb/test_mdio_mgmt_engine.sv
`timescale 1ns/1ps
module test_mdio_mgmt_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [1:0]  reg_rd_addr = 2'd2;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int nchk = 0;
  int nfail = 0;
  int rises = 0;
  int data_off = 0;
  logic [15:0] resp = 16'h0;
  logic cap_oe [0:63];
  logic cap_o  [0:63];

  always #2.5 clk = ~clk;

  mdio_mgmt_engine i_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: record each bit at rising MDC, present reply bits after falling MDC
  always @(posedge mdc) begin
    if (rises < 64) begin
      cap_oe[rises] = mdio_oe;
      cap_o[rises]  = mdio_o;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    #1;
    if (rises >= data_off && rises < data_off + 16) mdio_i = resp[15 - (rises - data_off)];
    else mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd_addr = a;
    #0.5;
    d = reg_rdata;
    reg_rd_addr = 2'd2;
    #0.1;
  endtask

  // Counts cycles with busy set, starting at the current negedge
  task automatic wait_idle(output int n);
    n = 0;
    reg_rd_addr = 2'd2;
    #0.1;
    while (reg_rdata[0] && n < 20000) begin
      n++;
      @(negedge clk);
      #0.1;
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rdop, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] wd, input bit sup);
    logic [31:0] body;
    body = {2'b01, (rdop ? 2'b10 : 2'b01), phy, rg, (rdop ? 2'b11 : 2'b10),
            (rdop ? 16'hFFFF : wd)};
    return sup ? {body, 32'h0} : {32'hFFFF_FFFF, body};
  endfunction

  task automatic check_frame(input string req, input bit rdop, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] wd, input bit sup);
    logic [63:0] ef;
    int n, off, bad;
    ef  = exp_frame(rdop, phy, rg, wd, sup);
    n   = sup ? 32 : 64;
    off = sup ? 0 : 32;
    bad = 0;
    check({req, " bit count"}, rises, n);
    for (int k = 0; k < n; k++) begin
      if (rdop && k >= off + 14) begin
        if (cap_oe[k] !== 1'b0) bad++;
      end else begin
        if (cap_oe[k] !== 1'b1 || cap_o[k] !== ef[63 - k]) bad++;
      end
    end
    check({req, " bad frame bits"}, bad, 0);
  endtask

  task automatic prep(input bit sup, input logic [15:0] r);
    rises = 0;
    data_off = (sup ? 0 : 32) + 16;
    resp = r;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd2, d); check("R1 status", d, 16'h0);
    rd(2'd3, d); check("R1 ctrl", d, 16'd39 << 9);
    rd(2'd1, d); check("R1 data", d, 16'h0);
    check("R1 mdc", mdc, 1'b0);
    check("R1 oe", mdio_oe, 1'b0);
  endtask

  task automatic t_write_pre();
    int n; logic [15:0] d;
    wr(2'd3, 16'd3 << 9);
    wr(2'd1, 16'hA5C3);
    prep(1'b0, 16'h0);
    wr(2'd0, 16'h4000 | (16'h13 << 5) | 16'h0A);
    wait_idle(n);
    check("R6 busy cycles 64x4", n, 256);
    check_frame("R3 R4 write frame", 1'b0, 5'h13, 5'h0A, 16'hA5C3, 1'b0);
    rd(2'd1, d); check("R4 data kept", d, 16'hA5C3);
  endtask

  task automatic t_read_sup();
    int n; logic [15:0] d;
    wr(2'd3, (16'd4 << 9) | 16'h0100);
    prep(1'b1, 16'h3C96);
    wr(2'd0, 16'h8000 | (16'h01 << 5) | 16'h02);
    wait_idle(n);
    rd(2'd1, d); check("R5 read data at busy low", d, 16'h3C96);
    check("R8 busy cycles 32x5", n, 160);
    check_frame("R5 R8 read frame", 1'b1, 5'h01, 5'h02, 16'h0, 1'b1);
  endtask

  task automatic t_mdc_shape();
    int n; logic [11:0] pat;
    wr(2'd3, (16'd5 << 9) | 16'h0100);
    prep(1'b1, 16'h0);
    wr(2'd0, 16'h4000);
    for (int i = 0; i < 12; i++) begin
      pat[11 - i] = mdc;
      @(negedge clk);
    end
    check("R7 mdc shape D=6", pat, 12'b000111000111);
    wait_idle(n);
    check("R7 busy cycles D=6", n, 32 * 6 - 12);
    wr(2'd3, 16'h0100);
    prep(1'b1, 16'h0);
    wr(2'd0, 16'h4000);
    wait_idle(n);
    check("R7 clamp D=2", n, 64);
  endtask

  task automatic t_busy_ignore();
    int n; logic [15:0] d;
    wr(2'd3, (16'd3 << 9) | 16'h0100);
    prep(1'b1, 16'h1234);
    wr(2'd0, 16'h8000 | (16'h03 << 5) | 16'h04);
    repeat (8) @(negedge clk);
    wr(2'd0, 16'h4000 | 16'h03FF);
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'd9 << 9);
    wait_idle(n);
    check_frame("R9 frame unchanged", 1'b1, 5'h03, 5'h04, 16'h0, 1'b1);
    rd(2'd1, d); check("R9 data write ignored", d, 16'h1234);
    rd(2'd3, d); check("R9 ctrl write ignored", d, (16'd3 << 9) | 16'h0100);
    rd(2'd0, d); check("R9 cmd write ignored", d, 16'h8000 | (16'h03 << 5) | 16'h04);
  endtask

  task automatic t_opcodes();
    int n; logic [15:0] d;
    prep(1'b1, 16'hBEEF);
    wr(2'd0, 16'hC000 | (16'h07 << 5) | 16'h11);
    wait_idle(n);
    check_frame("R2 both bits read wins", 1'b1, 5'h07, 5'h11, 16'h0, 1'b1);
    rd(2'd1, d); check("R2 both bits data", d, 16'hBEEF);
    prep(1'b1, 16'h0);
    wr(2'd0, 16'h03FF);
    repeat (10) @(negedge clk);
    rd(2'd2, d); check("R2 no opcode stays idle", d, 16'h0);
    check("R2 no opcode no mdc", rises, 0);
  endtask

  task automatic t_self_clear();
    int n, r0; logic [15:0] d;
    wr(2'd1, 16'h5555);
    prep(1'b0, 16'h0);
    wr(2'd0, 16'h4000 | 16'h21);
    repeat (20) @(negedge clk);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); check("R10 clear bit visible", d[0], 1'b1);
    @(negedge clk);
    rd(2'd2, d); check("R10 idle after clear", d, 16'h0);
    rd(2'd3, d); check("R10 ctrl defaults", d, 16'd39 << 9);
    rd(2'd1, d); check("R10 data cleared", d, 16'h0);
    check("R10 oe released", mdio_oe, 1'b0);
    r0 = rises;
    repeat (40) @(negedge clk);
    check("R10 mdc stopped", rises, r0);
    prep(1'b0, 16'h0);
    wr(2'd0, 16'h4000);
    wait_idle(n);
    check("R7 default divisor 64x40", n, 2560);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_pre();
    t_read_sup();
    t_mdc_shape();
    t_busy_ignore();
    t_opcodes();
    t_self_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule